// File: doc/BRIEF.md
# Ring-Buffer Command Stream Parser

This block consumes a stream of 32-bit command words that a host writes into a circular region of shared memory. The region is described by a four-word header at word addresses 0 to 3: the lowest byte offset of the ring, the byte offset one past its end, the offset where the host will write next (the host advances it), and the offset where the parser will read next (the parser advances it and writes it back). The memory is reached through a simple word-addressed port with one cycle of read latency.

A run starts on either a sync request or a periodic tick. The parser reads the header and checks it. If the header is valid, it computes how many words are waiting and decodes commands one at a time. Rectangle update, solid fill and rectangle copy commands become requests to a drawing engine over a valid/ready handshake. Unsupported opcodes are skipped over their fixed argument counts so that the stream stays aligned. A command that is only partly present is rewound so that it can be parsed again on a later run. One run handles a bounded number of commands.

Top module: `cmd_ring_parser`

## Requirements
- R1: During and right after reset, `busy_o` and `req_valid_o` are 0 and the memory port neither reads nor writes. While idle, the port stays quiet.
- R2: A trigger (`sync_i` or `tick_i`) that arrives while `enable_i` and `configured_i` are not both 1 causes no memory access, and `busy_o` stays 0.
- R3: The header is rejected, so the run ends after its four header reads with the read pointer unchanged, when any of the following holds: one of the four offsets is not a multiple of 4; the low bound is below HDR_MIN (16); the end bound exceeds RING_BYTES (65536); the low bound, next or stop is at least RING_BYTES; or the end bound is below the low bound plus MIN_SPAN (10240).
- R4: The number of waiting words is (next − stop) / 4 when next ≥ stop. Otherwise it is (next − stop + end − low) / 4.
- R5: Each word read fetches the word at byte offset stop (word address stop/4) and adds 4 to stop, wrapping to the low bound when stop reaches the end bound. The new stop is written to word address 3 in the cycle after the read. Reads and writes never share a cycle.
- R6: Opcodes 1 and 25 take four arguments and produce a request of kind 0 (update), with x, y, w, h in argument slots 0 to 3 (slot i is `req_args_o[32*i+31:32*i]`).
- R7: Opcode 2 takes five arguments and produces kind 1 (fill), with colour, x, y, w, h in slots 0 to 4.
- R8: Opcode 3 takes six arguments and produces kind 2 (copy), with source x, source y, destination x, destination y, w, h in slots 0 to 5.
- R9: Opcode 13 skips 6 words, opcode 14 skips 7 and opcode 28 skips 12. Every other opcode (including 0, 26, 27, 29, 30) skips none. None of these produce a request.
- R10: If fewer words are waiting after the opcode than its argument count, stop is restored to that command's opcode position and written to word address 3, and the run ends.
- R11: A run handles at most MAX_CMDS (1024) commands, then `busy_o` falls.
- R12: A request holds `req_valid_o`, its kind and its arguments unchanged until `req_ready_i` is seen. No memory access takes place while the request is pending.
- R13: A trigger that arrives while `busy_o` is 1 is ignored. It neither restarts nor extends the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Parser enabled |
| configured_i | input | 1 | Ring memory configured |
| sync_i | input | 1 | Sync request pulse, starts a run |
| tick_i | input | 1 | Periodic trigger pulse, starts a run |
| mem_addr_o | output | MEM_AW | Word address for a read or write |
| mem_rd_o | output | 1 | Read strobe; data returns next cycle |
| mem_we_o | output | 1 | Write strobe (stop write-back) |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after `mem_rd_o` |
| busy_o | output | 1 | A run is in progress |
| req_valid_o | output | 1 | Drawing request pending |
| req_ready_i | input | 1 | Drawing engine accepts the request |
| req_kind_o | output | 2 | 0 update, 1 fill, 2 copy |
| req_args_o | output | 192 | Six 32-bit argument slots |

## Verification
The two functions that overlap are the drawing handshake and the run trigger. A request can be stalled by a low `req_ready_i` in the same cycle in which a sync or tick pulse arrives. The bench provokes this by holding ready mostly low with a pseudo-random pattern and pulsing the tick mid-run. It judges the result by checking that the accepted request sequence and the final stop word equal a single-run behavioural model. The stop wrap and its write-back also land in one cycle; a ring whose commands straddle the end bound covers this, judged the same way.

// File: rtl/ring_cmd_pkg.sv
package ring_cmd_pkg;

   localparam int ARG_SLOTS = 6;
   localparam int HDR_WORDS = 4;

   typedef enum logic [1:0] {
      KIND_UPDATE = 2'd0,
      KIND_FILL   = 2'd1,
      KIND_COPY   = 2'd2
   } req_kind_e;

   typedef enum logic [3:0] {
      S_IDLE, S_HRD, S_HCAP, S_EVAL, S_CMD,
      S_ORD, S_OCAP, S_DEC, S_REQ, S_REW
   } prs_state_e;

   // Words that follow an opcode in the stream
   function automatic logic [3:0] arg_count(input logic [31:0] op);
      case (op)
         32'd1, 32'd25: return 4'd4;
         32'd2:         return 4'd5;
         32'd3:         return 4'd6;
         32'd13:        return 4'd6;
         32'd14:        return 4'd7;
         32'd28:        return 4'd12;
         default:       return 4'd0;
      endcase
   endfunction

   function automatic logic emits_req(input logic [31:0] op);
      return (op == 32'd1) || (op == 32'd25) || (op == 32'd2) || (op == 32'd3);
   endfunction

   function automatic req_kind_e kind_of(input logic [31:0] op);
      case (op)
         32'd2:   return KIND_FILL;
         32'd3:   return KIND_COPY;
         default: return KIND_UPDATE;
      endcase
   endfunction

endpackage

// File: rtl/ring_hdr_check.sv
module ring_hdr_check #(
   parameter int RING_BYTES = 65536,
   parameter int MIN_SPAN   = 10240,
   parameter int HDR_MIN    = 16,
   parameter int OFS_W      = 17
)(
   input  logic [31:0]      lo_i,
   input  logic [31:0]      hi_i,
   input  logic [31:0]      nxt_i,
   input  logic [31:0]      stp_i,
   output logic             ok_o,
   output logic [OFS_W-1:0] words_o
);
   logic             aligned, bounds, span;
   logic [OFS_W-1:0] diff;

   assign aligned = ((lo_i | hi_i | nxt_i | stp_i) & 32'd3) == 32'd0;
   assign bounds  = (lo_i >= 32'(HDR_MIN)) && (hi_i <= 32'(RING_BYTES)) &&
                    (lo_i < 32'(RING_BYTES)) && (nxt_i < 32'(RING_BYTES)) &&
                    (stp_i < 32'(RING_BYTES));
   assign span    = {1'b0, hi_i} >= ({1'b0, lo_i} + 33'(MIN_SPAN));
   assign ok_o    = aligned && bounds && span;

   // modular arithmetic is exact here because a valid ring is below 2**OFS_W bytes
   always_comb begin
      diff = nxt_i[OFS_W-1:0] - stp_i[OFS_W-1:0];
      if (nxt_i < stp_i)
         diff = diff + hi_i[OFS_W-1:0] - lo_i[OFS_W-1:0];
   end

   assign words_o = ok_o ? (diff >> 2) : '0;
endmodule

// File: rtl/ring_stop_step.sv
module ring_stop_step #(
   parameter int OFS_W = 17
)(
   input  logic [OFS_W-1:0] stop_i,
   input  logic [OFS_W-1:0] lo_i,
   input  logic [OFS_W-1:0] hi_i,
   output logic [OFS_W-1:0] stop_o
);
   logic [OFS_W:0] inc;

   assign inc    = {1'b0, stop_i} + (OFS_W+1)'(4);
   assign stop_o = (inc >= {1'b0, hi_i}) ? lo_i : inc[OFS_W-1:0];
endmodule

// File: rtl/cmd_ring_parser.sv
module cmd_ring_parser
   import ring_cmd_pkg::*;
#(
   parameter  int RING_BYTES = 65536,
   parameter  int MIN_SPAN   = 10240,
   parameter  int HDR_MIN    = 16,
   parameter  int MAX_CMDS   = 1024,
   localparam int OFS_W      = $clog2(RING_BYTES) + 1,
   localparam int MEM_AW     = OFS_W - 2,
   localparam int CNT_W      = $clog2(MAX_CMDS + 1),
   localparam int ARGS_W     = ARG_SLOTS * 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              configured_i,
   input  logic              sync_i,
   input  logic              tick_i,
   output logic [MEM_AW-1:0] mem_addr_o,
   output logic              mem_rd_o,
   output logic              mem_we_o,
   output logic [31:0]       mem_wdata_o,
   input  logic [31:0]       mem_rdata_i,
   output logic              busy_o,
   output logic              req_valid_o,
   input  logic              req_ready_i,
   output logic [1:0]        req_kind_o,
   output logic [ARGS_W-1:0] req_args_o
);

   initial begin
      assert ((RING_BYTES >= 1024) && ((RING_BYTES & (RING_BYTES - 1)) == 0))
         else $error("RING_BYTES must be a power of two of at least 1024");
      assert (HDR_MIN >= 4 * HDR_WORDS) else $error("HDR_MIN must clear the header");
      assert (MIN_SPAN < RING_BYTES) else $error("MIN_SPAN too large");
      assert (MAX_CMDS > 0) else $error("MAX_CMDS must be positive");
   end

   prs_state_e       st_q;
   logic [1:0]       hidx_q;
   logic [31:0]      hdr_q [HDR_WORDS];
   logic [OFS_W-1:0] lo_q, hi_q, stop_q, start_q, len_q;
   logic [CNT_W-1:0] ncmd_q;
   logic [31:0]      op_q;
   logic [3:0]       need_q, aidx_q;
   logic             is_op_q;
   logic             hdr_ok, trig;
   logic [OFS_W-1:0] hdr_words, stop_nxt;

   assign trig = sync_i | tick_i;

   ring_hdr_check #(
      .RING_BYTES(RING_BYTES), .MIN_SPAN(MIN_SPAN),
      .HDR_MIN(HDR_MIN), .OFS_W(OFS_W)
   ) u_hdr (
      .lo_i(hdr_q[0]), .hi_i(hdr_q[1]), .nxt_i(hdr_q[2]), .stp_i(hdr_q[3]),
      .ok_o(hdr_ok), .words_o(hdr_words)
   );

   ring_stop_step #(.OFS_W(OFS_W)) u_step (
      .stop_i(stop_q), .lo_i(lo_q), .hi_i(hi_q), .stop_o(stop_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         hidx_q  <= '0;
         for (int i = 0; i < HDR_WORDS; i++) hdr_q[i] <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
         stop_q  <= '0;
         start_q <= '0;
         len_q   <= '0;
         ncmd_q  <= '0;
         op_q    <= '0;
         need_q  <= '0;
         aidx_q  <= '0;
         is_op_q <= 1'b0;
      end else begin
         case (st_q)
            S_IDLE: if (trig && enable_i && configured_i) begin
               hidx_q <= '0;
               st_q   <= S_HRD;
            end
            S_HRD:  st_q <= S_HCAP;
            S_HCAP: begin
               hdr_q[hidx_q] <= mem_rdata_i;
               hidx_q        <= hidx_q + 2'd1;
               st_q          <= (hidx_q == 2'd3) ? S_EVAL : S_HRD;
            end
            S_EVAL: begin
               lo_q   <= hdr_q[0][OFS_W-1:0];
               hi_q   <= hdr_q[1][OFS_W-1:0];
               stop_q <= hdr_q[3][OFS_W-1:0];
               len_q  <= hdr_words;
               ncmd_q <= '0;
               st_q   <= hdr_ok ? S_CMD : S_IDLE;
            end
            S_CMD: begin
               if ((len_q == '0) || (ncmd_q == CNT_W'(MAX_CMDS))) begin
                  st_q <= S_IDLE;
               end else begin
                  start_q <= stop_q;
                  is_op_q <= 1'b1;
                  st_q    <= S_ORD;
               end
            end
            S_ORD:  st_q <= S_OCAP;
            S_OCAP: begin
               stop_q <= stop_nxt;
               len_q  <= len_q - 1'b1;
               if (is_op_q) begin
                  op_q   <= mem_rdata_i;
                  need_q <= arg_count(mem_rdata_i);
                  st_q   <= S_DEC;
               end else begin
                  aidx_q <= aidx_q + 4'd1;
                  if (aidx_q == need_q - 4'd1)
                     st_q <= emits_req(op_q) ? S_REQ : S_CMD;
                  else
                     st_q <= S_ORD;
               end
            end
            S_DEC: begin
               is_op_q <= 1'b0;
               aidx_q  <= '0;
               if (OFS_W'(need_q) > len_q) begin
                  st_q <= S_REW;
               end else begin
                  ncmd_q <= ncmd_q + 1'b1;
                  st_q   <= (need_q == 4'd0) ? S_CMD : S_ORD;
               end
            end
            S_REQ:  if (req_ready_i) st_q <= S_CMD;
            S_REW: begin
               stop_q <= start_q;
               st_q   <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   // one register per argument slot, loaded in stream order
   for (genvar g = 0; g < ARG_SLOTS; g++) begin : g_slot
      logic [31:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if ((st_q == S_OCAP) && !is_op_q && (aidx_q == 4'(g)))
            slot_q <= mem_rdata_i;
      end
      assign req_args_o[g*32 +: 32] = slot_q;
   end

   assign busy_o      = (st_q != S_IDLE);
   assign req_valid_o = (st_q == S_REQ);
   assign req_kind_o  = kind_of(op_q);
   assign mem_rd_o    = (st_q == S_HRD) || (st_q == S_ORD);
   assign mem_we_o    = (st_q == S_OCAP) || (st_q == S_REW);
   assign mem_wdata_o = 32'((st_q == S_REW) ? start_q : stop_nxt);

   always_comb begin
      case (st_q)
         S_HRD:   mem_addr_o = MEM_AW'(hidx_q);
         S_ORD:   mem_addr_o = stop_q[OFS_W-1:2];
         default: mem_addr_o = MEM_AW'(3);
      endcase
   end
endmodule

// File: rtl/cmd_ring_parser_chk.sv
module cmd_ring_parser_chk #(
   parameter int MEM_AW = 15,
   parameter int ARGS_W = 192
)(
   input logic              clk,
   input logic              rst_n,
   input logic              enable_i,
   input logic              configured_i,
   input logic              sync_i,
   input logic              tick_i,
   input logic [MEM_AW-1:0] mem_addr_o,
   input logic              mem_rd_o,
   input logic              mem_we_o,
   input logic [31:0]       mem_wdata_o,
   input logic              busy_o,
   input logic              req_valid_o,
   input logic              req_ready_i,
   input logic [1:0]        req_kind_o,
   input logic [ARGS_W-1:0] req_args_o
);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mem_rd_o && !mem_we_o && !req_valid_o));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && (sync_i || tick_i) && !(enable_i && configured_i)) |=> !busy_o);

   // R5
   wb_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> ((mem_addr_o == MEM_AW'(3)) && (mem_wdata_o[1:0] == 2'b00)));

   // R5
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |-> !mem_we_o);

   // R12
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !req_ready_i) |=>
         (req_valid_o && $stable(req_kind_o) && $stable(req_args_o)));

   // R12
   no_read_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> (busy_o && !mem_rd_o && !mem_we_o));
endmodule

bind cmd_ring_parser cmd_ring_parser_chk #(.MEM_AW(MEM_AW), .ARGS_W(ARGS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .configured_i(configured_i),
   .sync_i(sync_i), .tick_i(tick_i), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
   .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .busy_o(busy_o),
   .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_kind_o(req_kind_o),
   .req_args_o(req_args_o)
);

// File: tb/tb_cmd_ring_parser.sv
module tb_cmd_ring_parser;
   localparam longint RING = 65536;
   localparam longint SPAN = 10240;
   localparam int     MAXC = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic enable_i = 0, configured_i = 0, sync_i = 0, tick_i = 0, req_ready_i = 0;
   logic [14:0]  mem_addr_o;
   logic         mem_rd_o, mem_we_o, busy_o, req_valid_o;
   logic [31:0]  mem_wdata_o;
   logic [31:0]  mem_rdata_i = '0;
   logic [1:0]   req_kind_o;
   logic [191:0] req_args_o;

   cmd_ring_parser dut (
      .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .configured_i(configured_i),
      .sync_i(sync_i), .tick_i(tick_i), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
      .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .busy_o(busy_o), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
      .req_kind_o(req_kind_o), .req_args_o(req_args_o)
   );

   logic [31:0]  mem [int];
   int           total = 0, bad = 0, cyc = 0, rd_cnt = 0, ready_mode = 0;
   logic [15:0]  lfsr = 16'hACE1;
   int           exp_kind[$];
   int           exp_n[$];
   logic [191:0] exp_args[$];
   logic [31:0]  exp_stop;
   longint       wp, mn_b, mx_b;

   function automatic logic [31:0] rdm(input int k);
      return mem.exists(k) ? mem[k] : 32'h0;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // memory with one cycle of read latency
   initial forever begin
      @(posedge clk);
      if (mem_rd_o) begin
         mem_rdata_i <= rdm(int'(mem_addr_o));
         rd_cnt++;
      end
      if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
   end

   // drawing side, per-clock comparison, watchdog
   initial forever begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (ready_mode)
         0:       req_ready_i = 1'b1;
         1:       req_ready_i = lfsr[0];
         default: req_ready_i = lfsr[0] & lfsr[1] & lfsr[2];
      endcase
      if (req_valid_o && !busy_o) chk("R12 valid outside run", 1, 0);
      if (req_valid_o && req_ready_i) begin
         if (exp_kind.size() == 0) begin
            chk("R9 unexpected request", 1, 0);
         end else begin
            logic [191:0] m;
            string        tg;
            m  = {192{1'b1}} >> (32 * (6 - exp_n[0]));
            tg = (exp_kind[0] == 0) ? "R6" : (exp_kind[0] == 1) ? "R7" : "R8";
            chk(tg, 64'(req_kind_o), 64'(exp_kind[0]));
            total++;
            if ((req_args_o & m) !== (exp_args[0] & m)) begin
               bad++;
               $display("FAIL %s args act=%h exp=%h", tg, req_args_o & m, exp_args[0] & m);
            end
            void'(exp_kind.pop_front());
            void'(exp_n.pop_front());
            void'(exp_args.pop_front());
         end
      end
      if (cyc > 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog act=%0d exp=<150000", cyc);
         summary();
      end
   end

   function automatic int argc(input int op);
      case (op)
         1, 25:   return 4;
         2:       return 5;
         3, 13:   return 6;
         14:      return 7;
         28:      return 12;
         default: return 0;
      endcase
   endfunction

   task automatic model(input bit en, input bit cfg);
      longint mn, mx, nx, st, len, start;
      int ncmd, op, need, kind;
      logic [191:0] a;
      exp_kind.delete(); exp_n.delete(); exp_args.delete();
      exp_stop = rdm(3);
      if (!(en && cfg)) return;
      mn = rdm(0); mx = rdm(1); nx = rdm(2); st = rdm(3);
      if (((mn | mx | nx | st) & 3) != 0 || mn < 16 || mx > RING || mn >= RING ||
          nx >= RING || st >= RING || mx < mn + SPAN) return;
      len = nx - st;
      if (len < 0) len += mx - mn;
      len = len / 4;
      ncmd = 0;
      while (len > 0 && ncmd < MAXC) begin
         start = st;
         op = int'(rdm(int'(st / 4)));
         st += 4; if (st >= mx) st = mn;
         len--;
         need = argc(op);
         if (need > len) begin
            st = start;
            break;
         end
         ncmd++;
         a = '0;
         for (int i = 0; i < need; i++) begin
            if (i < 6) a[i*32 +: 32] = rdm(int'(st / 4));
            st += 4; if (st >= mx) st = mn;
            len--;
         end
         kind = (op == 2) ? 1 : (op == 3) ? 2 : 0;
         if (op == 1 || op == 25 || op == 2 || op == 3) begin
            exp_kind.push_back(kind);
            exp_n.push_back(need);
            exp_args.push_back(a);
         end
      end
      exp_stop = 32'(st);
   endtask

   task automatic set_ring(input longint mn, input longint mx, input longint st);
      mem.delete();
      mem[0] = 32'(mn); mem[1] = 32'(mx); mem[3] = 32'(st);
      wp = st; mn_b = mn; mx_b = mx;
   endtask

   task automatic put(input int w);
      mem[int'(wp / 4)] = 32'(w);
      wp += 4;
      if (wp >= mx_b) wp = mn_b;
   endtask

   task automatic close_ring();
      mem[2] = 32'(wp);
   endtask

   task automatic run_case(input string tg, input bit en, input bit cfg,
                           input int rmode, input bit dbl, input int exp_reads);
      model(en, cfg);
      ready_mode = rmode;
      enable_i = en; configured_i = cfg;
      rd_cnt = 0;
      @(negedge clk); sync_i = 1'b1;
      @(negedge clk); sync_i = 1'b0;
      if (dbl) begin
         repeat (12) @(negedge clk);
         chk("R13 busy before second trigger", 64'(busy_o), 1);
         tick_i = 1'b1;
         @(negedge clk); tick_i = 1'b0;
      end
      while (busy_o) @(negedge clk);
      repeat (3) @(negedge clk);
      chk({tg, " missing requests"}, 64'(exp_kind.size()), 0);
      chk({tg, " final stop"}, 64'(rdm(3)), 64'(exp_stop));
      if (exp_reads >= 0) chk({tg, " read count"}, 64'(rd_cnt), 64'(exp_reads));
      chk({tg, " idle after run"}, 64'(busy_o), 0);
   endtask

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", 64'(busy_o), 0);
      chk("R1 valid in reset", 64'(req_valid_o), 0);
      chk("R1 port quiet in reset", 64'(mem_rd_o | mem_we_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", 64'(busy_o), 0);

      // R2 not enabled or not configured
      set_ring(16, 16 + SPAN, 16);
      put(1); put(1); put(2); put(3); put(4); close_ring();
      run_case("R2 disabled", 0, 1, 0, 0, 0);
      run_case("R2 unconfigured", 1, 0, 0, 0, 0);

      // R3 header rejections
      set_ring(16, 16 + SPAN, 16);
      put(1); put(1); put(2); put(3); put(4); close_ring();
      mem[2] = mem[2] + 2;
      run_case("R3 misaligned", 1, 1, 0, 0, 4);
      set_ring(8, 8 + SPAN, 8);
      put(1); put(1); put(2); put(3); put(4); close_ring();
      run_case("R3 low bound", 1, 1, 0, 0, 4);
      set_ring(RING - SPAN, RING + 4, RING - SPAN);
      put(1); put(1); put(2); put(3); put(4); close_ring();
      run_case("R3 end bound", 1, 1, 0, 0, 4);
      set_ring(16, 16 + SPAN - 4, 16);
      put(1); put(1); put(2); put(3); put(4); close_ring();
      run_case("R3 short span", 1, 1, 0, 0, 4);

      // R6 R7 R8 drawing requests
      set_ring(64, 64 + SPAN, 64);
      put(1); put(10); put(20); put(30); put(40);
      put(2); put(32'h00ff00); put(5); put(6); put(7); put(8);
      put(3); put(11); put(12); put(13); put(14); put(15); put(16);
      put(25); put(100); put(200); put(300); put(400);
      close_ring();
      run_case("R6 R7 R8 mixed", 1, 1, 0, 0, 4 + 23);

      // R9 skipped opcodes, stream stays aligned
      set_ring(16, 16 + SPAN, 16);
      put(13); for (int i = 0; i < 6; i++) put(1);
      put(14); for (int i = 0; i < 7; i++) put(2);
      put(28); for (int i = 0; i < 12; i++) put(3);
      put(0); put(26); put(27); put(29); put(30); put(7); put(22);
      put(1); put(9); put(8); put(7); put(6);
      close_ring();
      run_case("R9 skip", 1, 1, 1, 0, -1);

      // R4 R5 wrap across the end bound, next below stop
      set_ring(16, 16 + SPAN, 16 + SPAN - 12);
      put(1); put(21); put(22); put(23); put(24);
      put(2); put(5); put(51); put(52); put(53); put(54);
      close_ring();
      run_case("R4 R5 wrap", 1, 1, 1, 0, 4 + 11);

      // R10 partial command rewinds
      set_ring(16, 16 + SPAN, 16);
      put(1); put(1); put(2); put(3); put(4);
      put(3); put(7); put(7); put(7);
      close_ring();
      run_case("R10 partial", 1, 1, 0, 0, 4 + 6);
      chk("R10 stop at opcode", 64'(rdm(3)), 16 + 20);

      // R11 command limit, ring at the top of the space
      set_ring(RING - SPAN, RING, RING - SPAN);
      for (int i = 0; i < MAXC + 6; i++) put(0);
      close_ring();
      run_case("R11 limit", 1, 1, 0, 0, 4 + MAXC);
      chk("R11 stop after limit", 64'(rdm(3)), 64'(RING - SPAN + 4 * MAXC));

      // R12 R13 stalled requests with a trigger during the run
      set_ring(16, 16 + SPAN, 16);
      for (int i = 0; i < 6; i++) begin
         put(1); put(i); put(i + 1); put(i + 2); put(i + 3);
      end
      close_ring();
      run_case("R12 R13 stall", 1, 1, 2, 1, 4 + 30);

      summary();
   end
endmodule